// File: doc/BRIEF.md
# Byte-Access Console UART Register Window

This block gives a processor a two-byte register window onto a console serial port. Loads and stores arrive on a simple request/response bus: a request carries a device-local offset, an access width, a read/write flag and a write byte. Exactly one cycle later the block answers with read data and a fault flag. A byte store to the data location hands a character to the transmit side. A byte load from the same location takes the oldest character out of a small receive queue. A byte load from the status location reports whether the transmitter and the receiver are ready.

Received characters come in on a byte stream that has a valid strobe and no back-pressure. They collect in a parameterised FIFO, and a character that arrives while the FIFO is full is lost. Outgoing characters leave on a valid/ready byte stream through a one-entry holding register. The status byte always reports the transmitter as ready, so software never polls it. Every access the window does not define answers with an access fault and changes nothing: a wider access, a store to the status byte, or any offset above 1. Serial bit timing belongs to the neighbouring logic.

Top module: `uart_byte_window`

## Requirements
- R1: A byte write (size code 0) to offset 0 completes without fault, and the written byte appears on the transmit stream (`tx_valid` high, `tx_data` equal to the byte) from the cycle after the request.
- R2: A byte read of offset 0 while the receive FIFO holds data returns the oldest byte without fault and removes it, so successive reads return bytes in arrival order.
- R3: A byte read of offset 0 while the receive FIFO is empty returns 0x00 without fault.
- R4: A byte read of offset 1 returns a status byte: bit 0 is always 1 (transmit ready), bit 1 is 1 exactly when the receive FIFO is non-empty, and bits 7..2 are 0.
- R5: A byte write to offset 1 or to any offset above 1 faults, puts nothing on the transmit stream and leaves the receive FIFO unchanged.
- R6: A byte read at any offset above 1 faults.
- R7: Any access whose size code is not 0 (1 = halfword, 2 = word, 3 = doubleword) faults at every offset, neither pops the FIFO nor transmits.
- R8: Every request (`req_valid` high at a clock edge) gets exactly one response, `rsp_valid` high in the following cycle only, and a faulting response carries `rsp_rdata` = 0x00.
- R9: The receive FIFO holds `FIFO_DEPTH` bytes. A byte offered on `rx_valid` while it is full is discarded.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady. A data write that arrives then is discarded. A data write in a cycle where the held byte is accepted replaces it.
- R11: After reset no response is pending, `tx_valid` is low and the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_offset | input | OFS_W | Device-local byte offset |
| req_size | input | 2 | Access width code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 8 | Load data (0x00 on fault and for stores) |
| rsp_fault | output | 1 | Access fault |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit side accepts the byte |

## Verification
The bench builds the window with `FIFO_DEPTH` = 4 and `OFS_W` = 3. With these values a full sweep of every read/write, offset and size combination is only 64 requests, so each fault rule is checked at every offset rather than a sample. The shallow FIFO also makes it cheap to overfill the queue by two bytes and to read it back through to empty, covering the drop rule and the empty-read rule in the same sequence. The transmit holding register is stalled and released by the bench to cover both the discard and the hold cases.

// File: rtl/uart_win_pkg.sv
package uart_win_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE  = 2'd0,
      ACC_HALF  = 2'd1,
      ACC_WORD  = 2'd2,
      ACC_DWORD = 2'd3
   } acc_size_e;

   localparam int unsigned CHAR_W = 8;

   // status byte bit positions
   localparam int unsigned STAT_TX_BIT = 0;
   localparam int unsigned STAT_RX_BIT = 1;

   typedef struct packed {
      logic data_wr;
      logic data_rd;
      logic stat_rd;
      logic fault;
   } win_dec_t;

endpackage

// File: rtl/uart_win_decode.sv
module uart_win_decode
   import uart_win_pkg::*;
#(
   parameter int unsigned OFS_W = 4
) (
   input  logic             valid,
   input  logic             write,
   input  logic [OFS_W-1:0] offset,
   input  logic [1:0]       size,
   output win_dec_t         dec
);

   logic hi_zero;
   logic is_byte;
   logic ofs_zero;
   logic ofs_one;

   generate
      if (OFS_W == 1) begin : g_narrow
         assign hi_zero = 1'b1;
      end else begin : g_wide
         assign hi_zero = (offset[OFS_W-1:1] == '0);
      end
   endgenerate

   assign is_byte  = (acc_size_e'(size) == ACC_BYTE);
   assign ofs_zero = hi_zero & ~offset[0];
   assign ofs_one  = hi_zero &  offset[0];

   always_comb begin
      dec.data_wr = valid &  write & is_byte & ofs_zero;
      dec.data_rd = valid & ~write & is_byte & ofs_zero;
      dec.stat_rd = valid & ~write & is_byte & ofs_one;
      dec.fault   = valid & ~(dec.data_wr | dec.data_rd | dec.stat_rd);
   end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q;
   logic [AW-1:0] rp_q;
   logic [AW:0]   cnt_q;
   logic          push_ok;
   logic          pop_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == FULL_CNT);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem_q[wp_q] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         tx_valid,
   output logic [W-1:0] tx_data,
   input  logic         tx_ready
);

   logic         full_q;
   logic [W-1:0] data_q;
   logic         can_load;

   // a slot is free when empty or when the held byte leaves this cycle
   assign can_load = ~full_q | tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (wr_en && can_load) begin
         full_q <= 1'b1;
         data_q <= wr_data;
      end else if (tx_ready) begin
         full_q <= 1'b0;
      end
   end

   assign tx_valid = full_q;
   assign tx_data  = data_q;

endmodule

// File: rtl/uart_byte_window.sv
module uart_byte_window
   import uart_win_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned OFS_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [1:0]       req_size,
   input  logic [7:0]       req_wdata,
   output logic             rsp_valid,
   output logic [7:0]       rsp_rdata,
   output logic             rsp_fault,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   input  logic             tx_ready
);

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (OFS_W < 1) begin : g_bad_ofs
         $error("OFS_W must be at least 1");
      end
   endgenerate

   win_dec_t          dec;
   logic [CHAR_W-1:0] rx_head;
   logic              rx_empty;
   logic              rx_full;
   logic [CHAR_W-1:0] status_byte;
   logic [CHAR_W-1:0] rdata_d;

   uart_win_decode #(.OFS_W(OFS_W)) u_dec (
      .valid  (req_valid),
      .write  (req_write),
      .offset (req_offset),
      .size   (req_size),
      .dec    (dec)
   );

   uart_rx_queue #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_valid),
      .push_data (rx_data),
      .pop       (dec.data_rd),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   uart_tx_hold #(.W(CHAR_W)) u_txh (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dec.data_wr),
      .wr_data  (req_wdata),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_ready (tx_ready)
   );

   always_comb begin
      status_byte              = '0;
      status_byte[STAT_TX_BIT] = 1'b1;
      status_byte[STAT_RX_BIT] = ~rx_empty;
   end

   always_comb begin
      rdata_d = '0;
      if (dec.data_rd && !rx_empty) rdata_d = rx_head;
      else if (dec.stat_rd)         rdata_d = status_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= rdata_d;
         rsp_fault <= dec.fault;
      end
   end

endmodule

// File: rtl/uart_byte_window_chk.sv
module uart_byte_window_chk #(
   parameter int unsigned OFS_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [OFS_W-1:0] req_offset,
   input logic [1:0]       req_size,
   input logic             rsp_valid,
   input logic [7:0]       rsp_rdata,
   input logic             rsp_fault,
   input logic             tx_valid,
   input logic [7:0]       tx_data,
   input logic             tx_ready
);

   // R7
   wide_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'd0) |=> (rsp_valid && rsp_fault));

   // R8
   one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R8
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R8
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_rdata == 8'h00));

   // R4
   status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0 && req_offset == OFS_W'(1))
      |=> (!rsp_fault && rsp_rdata[0] && rsp_rdata[7:2] == 6'd0));

   // R6
   high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_offset > OFS_W'(1)) |=> rsp_fault);

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind uart_byte_window uart_byte_window_chk #(.OFS_W(OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_offset (req_offset),
   .req_size   (req_size),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .rsp_fault  (rsp_fault),
   .tx_valid   (tx_valid),
   .tx_data    (tx_data),
   .tx_ready   (tx_ready)
);

// File: tb/tb_uart_byte_window.sv
`timescale 1ns/100ps
module tb_uart_byte_window;

   localparam int unsigned DEPTH = 4;
   localparam int unsigned OW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [OW-1:0] req_offset = '0;
   logic [1:0]    req_size = '0;
   logic [7:0]    req_wdata = '0;
   logic          rsp_valid;
   logic [7:0]    rsp_rdata;
   logic          rsp_fault;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          tx_valid;
   logic [7:0]    tx_data;
   logic          tx_ready = 1'b1;

   int checks = 0;
   int errors = 0;
   logic [7:0] tx_log [256];
   int ntx = 0;
   logic [7:0] got_data;
   logic       got_fault;
   logic       got_valid;

   always #2.5 clk = ~clk;

   uart_byte_window #(.FIFO_DEPTH(DEPTH), .OFS_W(OW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
   );

   // transmit monitor, sampled just after the falling edge
   always begin
      @(negedge clk);
      #1;
      if (tx_valid && tx_ready && ntx < 256) begin
         tx_log[ntx] = tx_data;
         ntx++;
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic access(logic wr, int ofs, int sz, logic [7:0] wd);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_offset = OW'(ofs);
      req_size   = 2'(sz);
      req_wdata  = wd;
      @(negedge clk);
      req_valid  = 1'b0;
      got_valid  = rsp_valid;
      got_data   = rsp_rdata;
      got_fault  = rsp_fault;
   endtask

   task automatic push_rx(logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int exp_tx [64];
      int nexp;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 rsp_valid", rsp_valid, 0);
      check("R11 tx_valid", tx_valid, 0);
      access(1'b0, 1, 0, 8'h00);
      check("R11 status after reset", got_data, 8'h01);

      // full sweep: read/write x offset x size, FIFO empty, tx_ready high
      nexp = 0;
      base = ntx;
      for (int wr = 0; wr < 2; wr++) begin
         for (int ofs = 0; ofs < 8; ofs++) begin
            for (int sz = 0; sz < 4; sz++) begin
               logic [7:0] wd;
               int efault;
               int edata;
               wd = 8'(8'h40 + ofs * 4 + sz);
               efault = (sz != 0) || (wr == 1 && ofs != 0) || (wr == 0 && ofs > 1);
               edata = (!efault && wr == 0 && ofs == 1) ? 8'h01 : 8'h00;
               access(wr[0], ofs, sz, wd);
               check("R8 rsp_valid", got_valid, 1);
               if (sz != 0) check("R7 wide access fault", got_fault, efault);
               else if (wr == 1) check("R5 byte write fault", got_fault, efault);
               else if (ofs > 1) check("R6 high read fault", got_fault, efault);
               else check("R3 R4 low read fault", got_fault, efault);
               check("R8 R3 R4 rdata", got_data, edata);
               if (!efault && wr == 1) begin
                  exp_tx[nexp] = wd;
                  nexp++;
               end
            end
         end
      end
      @(negedge clk);
      check("R8 idle rsp_valid", rsp_valid, 0);
      repeat (3) @(negedge clk);
      check("R1 R5 R7 tx count", ntx - base, nexp);
      for (int i = 0; i < nexp; i++) check("R1 tx byte", tx_log[base + i], exp_tx[i]);

      // R4 status with data, R7 wide read does not pop
      push_rx(8'h5A);
      access(1'b0, 1, 0, 8'h00);
      check("R4 status with rx data", got_data, 8'h03);
      access(1'b0, 0, 1, 8'h00);
      check("R7 halfword read fault", got_fault, 1);
      access(1'b1, 1, 0, 8'h77);
      check("R5 status write fault", got_fault, 1);
      access(1'b0, 0, 0, 8'h00);
      check("R2 R7 R5 byte survives", got_data, 8'h5A);
      check("R2 no fault", got_fault, 0);
      access(1'b0, 1, 0, 8'h00);
      check("R2 status after pop", got_data, 8'h01);

      // R9 overfill by two, R2 order, R3 empty read
      for (int i = 0; i < DEPTH + 2; i++) push_rx(8'(8'h10 + i));
      for (int i = 0; i < DEPTH; i++) begin
         access(1'b0, 0, 0, 8'h00);
         check("R2 R9 fifo order", got_data, 8'h10 + i);
      end
      access(1'b0, 0, 0, 8'h00);
      check("R9 extra bytes dropped", got_data, 8'h00);
      check("R3 empty read no fault", got_fault, 0);

      // R10 stalled transmit
      @(negedge clk);
      tx_ready = 1'b0;
      base = ntx;
      access(1'b1, 0, 0, 8'hA1);
      check("R10 tx_valid", tx_valid, 1);
      access(1'b1, 0, 0, 8'hB2);
      check("R10 write accepted", got_fault, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R10 held data", tx_data, 8'hA1);
      end
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 drained count", ntx - base, 1);
      check("R10 drained byte", tx_log[base], 8'hA1);
      check("R10 tx idle", tx_valid, 0);

      // R10 replace while draining
      tx_ready = 1'b0;
      base = ntx;
      access(1'b1, 0, 0, 8'hC3);
      tx_ready = 1'b1;
      access(1'b1, 0, 0, 8'hD4);
      repeat (3) @(negedge clk);
      check("R10 replace count", ntx - base, 2);
      check("R10 replace first", tx_log[base], 8'hC3);
      check("R10 replace second", tx_log[base + 1], 8'hD4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule